// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output-compare channel that sits beside a timer counter. It watches the counter value that the timer supplies, compares it against an active compare value, and produces a registered reference level together with a one-cycle match flag. The counter, its direction and its update-event strobe all come from outside. The compare value and an 8-bit control byte are loaded through two simple write strobes.

The control byte selects one of eight behaviours for the reference level. The reference can ignore matches, be set or cleared or toggled on a match, or be forced to either level. It can also follow one of two pulse-width patterns that take the count direction into account. A preload option routes compare writes into a shadow register, and the shadow value reaches the comparator only on an update event. A clear-enable option lets an external clear input pull the reference low and keep it low until the next update event.

Internally the reference is a three-state machine:
- LEVEL_LOW and LEVEL_HIGH carry the output level. They move to each other on the transitions rise and fall, which the mode evaluator decides.
- HELD_CLEARED holds the output low. The transition clamp enters it from either level state. The transition release leaves it for LEVEL_LOW when an update event arrives with no clear request in the same cycle.
- The transition park sends either level state to LEVEL_LOW while the channel selection field is non-zero.

Top module: `oc_channel`

## Requirements
- R1: After reset, ref_out and match_out are 0, the control byte is 0 (mode 0, every option off) and the active compare value is 0.
- R2: The control byte is decoded as follows: bit 7 is clear enable, bits 6:4 are the mode, bit 3 is preload enable, bit 2 is the fast bit and bits 1:0 are the channel selection. A byte written at a clock edge governs the outputs from the following edge on.
- R3: match_out is 1 after an edge exactly when, at that edge, the counter equalled the active compare value. This holds in every mode.
- R4: In mode 0 the reference keeps its level whatever the counter does.
- R5: In mode 1 a match drives the reference to 1. In mode 2 a match drives it to 0. Without a match the level is kept.
- R6: In mode 3 every match inverts the reference.
- R7: Mode 4 forces the reference to 0 and mode 5 forces it to 1, whatever the counter value.
- R8: In mode 6, when counting up (cnt_down=0) the reference is 1 while counter < compare and 0 otherwise. When counting down (cnt_down=1) it is 0 while counter > compare and 1 otherwise.
- R9: Mode 7 produces the complement of the mode 6 level for the same counter, compare value and direction.
- R10: With preload disabled, a compare write at an edge becomes the active compare value for the next edge.
- R11: With preload enabled, a compare write only fills the shadow register. An update event copies the shadow value, as it stood before that edge, into the active compare value.
- R12: With clear enable set, ext_clr=1 drives the reference to 0. The reference stays at 0 until an edge that has an update event and no clear request, and at that edge it also returns 0.
- R13: A non-zero channel selection holds the reference at 0. The fast bit has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Counter value from the timer |
| cnt_down | input | 1 | Count direction, 1 = counting down |
| upd_evt | input | 1 | Update-event strobe |
| cmp_wr_en | input | 1 | Compare-value write strobe |
| cmp_wr_data | input | CNT_W | Compare value to write |
| ctl_wr_en | input | 1 | Control-byte write strobe |
| ctl_wr_data | input | 8 | Control byte to write |
| ext_clr | input | 1 | External clear request |
| ref_out | output | 1 | Registered reference level |
| match_out | output | 1 | One-cycle match flag |

## Verification
The bench checks the equality point of the pulse-width modes in both directions. A design that uses the wrong comparator there would get the level wrong at that point in one direction. It writes a compare value under preload and expects no match until an update event has passed; a design with a leaky shadow register would flag the match too early. It checks that the clamp still holds across an update event that coincides with a clear request, which a design that lets the update win would release. It also checks that a control write only takes effect one edge later, so off-by-one decoding of the control byte is exposed. Random sweeps then mix all eight modes with writes, update events and clears, and compare both outputs every cycle against a model.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int CTL_W = 8;

    typedef enum logic [2:0] {
        OCM_FROZEN      = 3'd0,
        OCM_SET_ON_HIT  = 3'd1,
        OCM_CLR_ON_HIT  = 3'd2,
        OCM_FLIP_ON_HIT = 3'd3,
        OCM_FORCE_LO    = 3'd4,
        OCM_FORCE_HI    = 3'd5,
        OCM_PWM_A       = 3'd6,
        OCM_PWM_B       = 3'd7
    } oc_mode_e;

    // Packed order fixes the bit positions: clr_en=7, mode=6:4, preload=3, fast=2, sel=1:0
    typedef struct packed {
        logic     clr_en;
        oc_mode_e mode;
        logic     preload;
        logic     fast;
        logic [1:0] sel;
    } oc_ctl_t;

    typedef enum logic [1:0] {
        LEVEL_LOW    = 2'd0,
        LEVEL_HIGH   = 2'd1,
        HELD_CLEARED = 2'd2
    } oc_state_e;

endpackage

// File: rtl/oc_ctl_reg.sv
module oc_ctl_reg
    import oc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output oc_ctl_t          ctl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= oc_ctl_t'('0);
        end else if (wr_en) begin
            ctl <= oc_ctl_t'(wr_data);
        end
    end

    // R2: a written byte is visible on the next edge
    p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl == oc_ctl_t'($past(wr_data))));

endmodule

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preload,
    input  logic             upd,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            shadow_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= '0;
        end else if (!preload && wr_en) begin
            active <= wr_data;
        end else if (preload && upd) begin
            active <= shadow_q;
        end
    end

    // R10: direct write lands in the active value next edge
    p_direct_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload && wr_en) |=> (active == $past(wr_data)));

    // R11: under preload the active value moves only on update events
    p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (preload && !upd) |=> $stable(active));

endmodule

// File: rtl/oc_level_eval.sv
module oc_level_eval
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  oc_mode_e         mode,
    input  logic             cnt_down,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             cur_high,
    output logic             nxt_high,
    output logic             hit
);

    logic below;
    logic above;
    logic pwm_lvl;

    assign hit   = (cnt == cmp);
    assign below = (cnt < cmp);
    assign above = (cnt > cmp);

    // Up: high while below. Down: low while above, so the equal point is high.
    assign pwm_lvl = cnt_down ? !above : below;

    always_comb begin
        nxt_high = cur_high;
        unique case (mode)
            OCM_FROZEN:      nxt_high = cur_high;
            OCM_SET_ON_HIT:  nxt_high = hit ? 1'b1 : cur_high;
            OCM_CLR_ON_HIT:  nxt_high = hit ? 1'b0 : cur_high;
            OCM_FLIP_ON_HIT: nxt_high = hit ? !cur_high : cur_high;
            OCM_FORCE_LO:    nxt_high = 1'b0;
            OCM_FORCE_HI:    nxt_high = 1'b1;
            OCM_PWM_A:       nxt_high = pwm_lvl;
            OCM_PWM_B:       nxt_high = !pwm_lvl;
            default:         nxt_high = cur_high;
        endcase
    end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             upd_evt,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic             ctl_wr_en,
    input  logic [7:0]       ctl_wr_data,
    input  logic             ext_clr,
    output logic             ref_out,
    output logic             match_out
);

    oc_ctl_t          ctl;
    logic [CNT_W-1:0] active_cmp;
    oc_state_e        state_q;
    oc_state_e        state_d;
    logic             eval_high;
    logic             hit;
    logic             clr_req;
    logic             parked;

    oc_ctl_reg i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .ctl     (ctl)
    );

    oc_cmp_store #(.CNT_W(CNT_W)) i_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .preload (ctl.preload),
        .upd     (upd_evt),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .active  (active_cmp)
    );

    oc_level_eval #(.CNT_W(CNT_W)) i_eval (
        .mode     (ctl.mode),
        .cnt_down (cnt_down),
        .cnt      (cnt_val),
        .cmp      (active_cmp),
        .cur_high (state_q == LEVEL_HIGH),
        .nxt_high (eval_high),
        .hit      (hit)
    );

    assign clr_req = ctl.clr_en && ext_clr;
    assign parked  = (ctl.sel != 2'd0);

    // Next-state logic: clamp, release, park, rise, fall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HELD_CLEARED: begin
                if (clr_req)      state_d = HELD_CLEARED;
                else if (upd_evt) state_d = LEVEL_LOW;    // release
                else              state_d = HELD_CLEARED;
            end
            LEVEL_LOW, LEVEL_HIGH: begin
                if (clr_req)        state_d = HELD_CLEARED;  // clamp
                else if (parked)    state_d = LEVEL_LOW;     // park
                else if (eval_high) state_d = LEVEL_HIGH;    // rise / stay
                else                state_d = LEVEL_LOW;     // fall / stay
            end
            default: state_d = LEVEL_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LEVEL_LOW;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_out   <= 1'b0;
            match_out <= 1'b0;
        end else begin
            ref_out   <= (state_d == LEVEL_HIGH);
            match_out <= hit;
        end
    end

    // R3: flag follows equality at the previous edge
    p_match_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val == active_cmp) |=> match_out);
    p_match_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val != active_cmp) |=> !match_out);

    // R4: frozen keeps the level
    p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode == OCM_FROZEN && !parked && !clr_req && state_q != HELD_CLEARED)
        |=> $stable(ref_out));

    // R7: forced low
    p_force_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode == OCM_FORCE_LO) |=> !ref_out);

    // R12: clear request pulls low
    p_clear_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !ref_out);

    // R12: held until an update event
    p_held_stays_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HELD_CLEARED && !upd_evt) |=> (state_q == HELD_CLEARED));

    // R13: non-zero selection parks low
    p_sel_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        parked |=> !ref_out);

endmodule

// File: tb/test_oc_channel.sv
`timescale 1ns/1ps
module test_oc_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cnt_down = 1'b0;
    logic        upd_evt = 1'b0;
    logic        cmp_wr_en = 1'b0;
    logic [15:0] cmp_wr_data = '0;
    logic        ctl_wr_en = 1'b0;
    logic [7:0]  ctl_wr_data = '0;
    logic        ext_clr = 1'b0;
    logic        ref_out;
    logic        match_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    logic [7:0]  m_ctl = '0;
    logic [15:0] m_shadow = '0;
    logic [15:0] m_active = '0;
    bit          m_level = 0;
    bit          m_held = 0;

    always #2.5 clk = ~clk;

    oc_channel i_oc_channel (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ext_clr(ext_clr),
        .ref_out(ref_out), .match_out(match_out)
    );

    function automatic bit mode_level(int md, bit dn, int c, int k, bit cur);
        bit pw;
        pw = dn ? (c <= k) : (c < k);
        case (md)
            0: return cur;
            1: return (c == k) ? 1'b1 : cur;
            2: return (c == k) ? 1'b0 : cur;
            3: return (c == k) ? !cur : cur;
            4: return 1'b0;
            5: return 1'b1;
            6: return pw;
            default: return !pw;
        endcase
    endfunction

    function automatic string mode_tag(int md);
        case (md)
            0: return "R4";
            1, 2: return "R5";
            3: return "R6";
            4, 5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] c, input bit dn, input bit up,
                        input bit cwe, input logic [15:0] cwd,
                        input bit kwe, input logic [7:0] kwd, input bit xc,
                        input string t_ref, input string t_m);
        bit exp_lvl, exp_m, n_held;
        logic [15:0] n_act;
        string tr;
        @(negedge clk);
        cnt_val = c; cnt_down = dn; upd_evt = up; cmp_wr_en = cwe; cmp_wr_data = cwd;
        ctl_wr_en = kwe; ctl_wr_data = kwd; ext_clr = xc;
        exp_m = (c == m_active);
        tr = mode_tag(int'(m_ctl[6:4]));
        if (m_ctl[7] && xc) begin
            n_held = 1; exp_lvl = 0; tr = "R12";
        end else if (m_held) begin
            n_held = !up; exp_lvl = 0; tr = "R12";
        end else if (m_ctl[1:0] != 0) begin
            n_held = 0; exp_lvl = 0; tr = "R13";
        end else begin
            n_held = 0;
            exp_lvl = mode_level(int'(m_ctl[6:4]), dn, int'(c), int'(m_active), m_level);
        end
        if (t_ref != "") tr = t_ref;
        n_act = m_active;
        if (cwe && !m_ctl[3]) n_act = cwd;
        else if (up && m_ctl[3]) n_act = m_shadow;
        @(posedge clk);
        #1;
        check(tr, "ref_out", int'(ref_out), int'(exp_lvl));
        check((t_m != "") ? t_m : "R3", "match_out", int'(match_out), int'(exp_m));
        m_level = exp_lvl; m_held = n_held; m_active = n_act;
        if (cwe) m_shadow = cwd;
        if (kwe) m_ctl = kwd;
        cmp_wr_en = 0; ctl_wr_en = 0; upd_evt = 0; ext_clr = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "ref_out after reset", int'(ref_out), 0);
        check("R1", "match_out after reset", int'(match_out), 0);
        @(negedge clk); rst_n = 1;
        // R1: active compare 0 and frozen mode
        step(16'd0, 0, 0, 0, 0, 0, 0, 0, "R1", "R1");
        // R2: control write takes effect one edge later
        step(16'd3, 0, 0, 0, 0, 1, 8'h50, 0, "R2", "");
        step(16'd3, 0, 0, 0, 0, 0, 0, 0, "R2", "");
        // R13: selection parks low, fast bit ignored
        step(16'd3, 0, 0, 0, 0, 1, 8'h51, 0, "", "");
        step(16'd3, 0, 0, 0, 0, 1, 8'h54, 0, "R13", "R13");
        step(16'd3, 0, 0, 0, 0, 0, 0, 0, "R13", "R13");
        // R10: direct compare write
        step(16'd7, 0, 0, 1, 16'd7, 0, 0, 0, "", "R10");
        step(16'd7, 0, 0, 0, 0, 0, 0, 0, "", "R10");
        // R11: preload
        step(16'd9, 0, 0, 0, 0, 1, 8'h08, 0, "", "");
        step(16'd9, 0, 0, 1, 16'd9, 0, 0, 0, "", "R11");
        step(16'd9, 0, 0, 0, 0, 0, 0, 0, "", "R11");
        step(16'd9, 0, 1, 0, 0, 0, 0, 0, "", "R11");
        step(16'd9, 0, 0, 0, 0, 0, 0, 0, "", "R11");
        // R12: clamp, hold through update with clear, release
        step(16'd1, 0, 0, 0, 0, 1, 8'hD0, 0, "", "");
        step(16'd1, 0, 0, 0, 0, 0, 0, 0, "", "");
        step(16'd1, 0, 0, 0, 0, 0, 0, 1, "R12", "");
        step(16'd1, 0, 1, 0, 0, 0, 0, 1, "R12", "");
        step(16'd1, 0, 0, 0, 0, 0, 0, 0, "R12", "");
        step(16'd1, 0, 1, 0, 0, 0, 0, 0, "R12", "");
        step(16'd1, 0, 0, 0, 0, 0, 0, 0, "R12", "");
        // R8 / R9: equality point in both directions (compare=9)
        step(16'd8, 0, 0, 0, 0, 1, 8'h60, 0, "", "");
        step(16'd8, 0, 0, 0, 0, 0, 0, 0, "R8", "");
        step(16'd9, 0, 0, 0, 0, 0, 0, 0, "R8", "");
        step(16'd9, 1, 0, 0, 0, 0, 0, 0, "R8", "");
        step(16'd10, 1, 0, 0, 0, 0, 0, 0, "R8", "");
        step(16'd8, 0, 0, 0, 0, 1, 8'h70, 0, "", "");
        step(16'd8, 0, 0, 0, 0, 0, 0, 0, "R9", "");
        // R6 toggle, R5 set/clear
        step(16'd9, 0, 0, 0, 0, 1, 8'h30, 0, "", "");
        step(16'd9, 0, 0, 0, 0, 0, 0, 0, "R6", "");
        step(16'd9, 0, 0, 0, 0, 0, 0, 0, "R6", "");
        step(16'd9, 0, 0, 0, 0, 1, 8'h20, 0, "", "");
        step(16'd9, 0, 0, 0, 0, 0, 0, 0, "R5", "");
        step(16'd9, 0, 0, 0, 0, 1, 8'h10, 0, "", "");
        step(16'd9, 0, 0, 0, 0, 0, 0, 0, "R5", "");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit kwe, cwe, up, xc, dn;
            logic [7:0] kwd;
            kwe = ($urandom % 20) == 0;
            kwd = {$urandom % 2 == 0, 3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2),
                   (($urandom % 6) == 0) ? 2'd1 : 2'd0};
            cwe = ($urandom % 8) == 0;
            up  = ($urandom % 10) == 0;
            xc  = ($urandom % 25) == 0;
            dn  = (i / 64) % 2 == 1;
            step(16'($urandom % 16), dn, up, cwe, 16'($urandom % 16), kwe, kwd, xc, "", "");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule